// File: doc/BRIEF.md
# Chainable Serial Command Word Receiver

This block takes 16-bit command words from a three-wire serial link: an active-low frame line, a serial clock and a data line. It samples all three pins in the system clock domain. When a frame closes correctly, it hands one word and a single-cycle valid strobe to the logic behind it. Data is captured on falling edges of the serial clock, and only while the frame line is low. The most significant bit arrives first.

With the chain enable low, the receiver keeps exactly the first 16 bits of a frame. It ignores any frame that closes early. With the chain enable high, it shifts for as long as the frame line stays low. It commits the last 16 bits it received and drives a serial output that repeats the input 16 serial clocks later. This lets several receivers share the clock and frame lines, with each serial output wired to the data input of the next stage. After a chained frame, the receiver must see one serial clock falling edge with the frame line high before it accepts another frame.

Top module: `serial_frame_rx`

## Requirements
- R1: Bits are taken on serial clock falling edges while frame_n_i is low. The first bit of a frame lands in bit 15 of word_o and the last bit in bit 0.
- R2: With chain_en_i low, a frame of exactly 16 falling edges produces one word_valid_o pulse when frame_n_i rises, with word_o holding the received word.
- R3: With chain_en_i low, a frame of fewer than 16 falling edges produces no pulse and leaves word_o unchanged.
- R4: With chain_en_i low, falling edges after the 16th in a frame are ignored, and the first 16 bits are committed.
- R5: With chain_en_i high, a frame of 16 or more falling edges commits the last 16 bits received. A frame of fewer than 16 commits nothing.
- R6: sdo_oe_o is high only while chain_en_i is high and the synchronized frame line is low. sdo_o shows the bit received 16 falling edges earlier.
- R7: After a frame closes with chain_en_i high, the next frame is ignored entirely unless a serial clock falling edge is first seen while frame_n_i is high. With chain_en_i low, frames may follow back to back.
- R8: word_valid_o is high for exactly one clock per commit. word_o holds between commits. Reset clears both.
- R9: The commit pulse appears on the third rising clk_i edge after frame_n_i rises (two synchronizer stages plus one edge-detect register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, data sampled on its falling edge |
| frame_n_i | input | 1 | Frame select, active low |
| sdin_i | input | 1 | Serial data in, MSB first |
| chain_en_i | input | 1 | Chain mode enable, held static during frames |
| sdo_o | output | 1 | Serial data out, input delayed by 16 serial clocks |
| sdo_oe_o | output | 1 | Output enable for the sdo pad driver |
| word_o | output | 16 | Last committed word |
| word_valid_o | output | 1 | One-cycle strobe on commit |

## Verification
Single-mode frames are sent with 16, 10 and 20 bits and with asymmetric patterns. These show the bit order, the exact-length rule and counter saturation apart from each other. Chained frames are sent with 32 and 8 bits. The 32-bit frame checks that only the tail of the stream is kept and that every forwarded bit arrives with exactly a 16-edge delay. The 8-bit frame checks the chained short-frame rule. A chained frame sent with no intervening serial clock edge, followed by one sent after such an edge, separates the re-arm rule from ordinary commit behaviour. Single-mode back-to-back frames show that the rule applies only in chained mode.

// File: rtl/serial_frame_rx_pkg.sv
package serial_frame_rx_pkg;
  typedef struct packed {
    logic sclk_fall;
    logic frame_fall;
    logic frame_rise;
  } ser_evt_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[b]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge
  import serial_frame_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_s_i,
  input  logic     frame_s_i,
  output ser_evt_t evt_o
);
  logic sclk_d_q, frame_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q  <= 1'b1;
      frame_d_q <= 1'b1;
    end else begin
      sclk_d_q  <= sclk_s_i;
      frame_d_q <= frame_s_i;
    end
  end

  assign evt_o.sclk_fall  = sclk_d_q & ~sclk_s_i;
  assign evt_o.frame_fall = frame_d_q & ~frame_s_i;
  assign evt_o.frame_rise = ~frame_d_q & frame_s_i;
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import serial_frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ser_evt_t          evt_i,
  input  logic              frame_low_i,
  input  logic              sdin_s_i,
  input  logic              chain_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              sdo_bit_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q, valid_q;
  logic              take;

  assign take = evt_i.sclk_fall & frame_low_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i.frame_fall) begin
        cnt_q <= '0;
      end else if (take) begin
        if (chain_en_i || cnt_q != FULL) shreg_q <= {shreg_q[WORD_W-2:0], sdin_s_i};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
      // idle-state falling edge re-arms after a chained frame
      if (evt_i.sclk_fall && !frame_low_i) armed_q <= 1'b1;
      if (evt_i.frame_rise) begin
        if (armed_q && cnt_q == FULL) begin
          word_q  <= shreg_q;
          valid_q <= 1'b1;
        end
        if (chain_en_i) armed_q <= 1'b0;
      end
    end
  end

  assign word_o    = word_q;
  assign valid_o   = valid_q;
  assign sdo_bit_o = shreg_q[WORD_W-1];

  // R4
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R3
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(word_q));
  // R7
  rearm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(evt_i.sclk_fall && !frame_low_i));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdin_i,
  input  logic              chain_en_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic [2:0] pins_s;
  ser_evt_t   evt;

  sfr_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, frame_n_i, sdin_i}),
    .q_o    (pins_s)
  );

  sfr_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (pins_s[2]),
    .frame_s_i (pins_s[1]),
    .evt_o     (evt)
  );

  sfr_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .frame_low_i (~pins_s[1]),
    .sdin_s_i    (pins_s[0]),
    .chain_en_i  (chain_en_i),
    .word_o      (word_o),
    .valid_o     (word_valid_o),
    .sdo_bit_o   (sdo_o)
  );

  assign sdo_oe_o = chain_en_i & ~pins_s[1];

  // R2
  commit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(evt.frame_rise));
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, frame_n = 1'b1, sdin = 1'b0, chain_en = 1'b0;
  logic sdo, sdo_oe, valid;
  logic [15:0] word;

  int n_run = 0, n_fail = 0;
  int pulses, lat;
  logic [15:0] cap;
  logic sdo_log [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_n_i(frame_n),
    .sdin_i(sdin), .chain_en_i(chain_en), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .word_o(word), .word_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b0; idle(HALF);
    sclk = 1'b1; idle(HALF);
  endtask

  // sends n bits of v, first bit v[n-1]; records sdo after each fall
  task automatic run_frame(input logic [63:0] v, input int n);
    frame_n = 1'b0; idle(HALF);
    for (int k = 0; k < n; k++) begin
      sdin = v[n-1-k];
      sclk = 1'b0; idle(HALF);
      sdo_log[k] = sdo;
      sclk = 1'b1; idle(HALF);
    end
    frame_n = 1'b1;
    pulses = 0; lat = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (valid) begin
        pulses++;
        cap = word;
        if (lat == 0) lat = i;
      end
    end
  endtask

  task automatic t_reset();
    check(valid == 1'b0, "R8 reset valid", 32'(valid), 0);
    check(word == 16'h0, "R8 reset word", 32'(word), 0);
    check(sdo_oe == 1'b0, "R6 reset oe", 32'(sdo_oe), 0);
  endtask

  task automatic t_exact();
    chain_en = 1'b0;
    run_frame(64'hA5C3, 16);
    check(pulses == 1, "R2 one pulse", 32'(pulses), 1);
    check(cap == 16'hA5C3, "R1 word order", 32'(cap), 32'hA5C3);
    check(lat == 3, "R9 latency", 32'(lat), 3);
    run_frame(64'h0001, 16);
    check(cap == 16'h0001 && pulses == 1, "R1 lsb last", 32'(cap), 32'h1);
  endtask

  task automatic t_short();
    run_frame(64'h2AB, 10);
    check(pulses == 0, "R3 no pulse", 32'(pulses), 0);
    check(word == 16'h0001, "R3 word kept", 32'(word), 32'h1);
  endtask

  task automatic t_long();
    run_frame({44'h0, 16'h3C5A, 4'h9}, 20);
    check(pulses == 1 && cap == 16'h3C5A, "R4 extra ignored", 32'(cap), 32'h3C5A);
    check(pulses == 1, "R8 single cycle", 32'(pulses), 1);
  endtask

  task automatic t_oe();
    chain_en = 1'b0; frame_n = 1'b0; idle(HALF);
    check(sdo_oe == 1'b0, "R6 oe chain off", 32'(sdo_oe), 0);
    frame_n = 1'b1; idle(HALF);
    chain_en = 1'b1; idle(2);
    check(sdo_oe == 1'b0, "R6 oe frame high", 32'(sdo_oe), 0);
    frame_n = 1'b0; idle(HALF);
    check(sdo_oe == 1'b1, "R6 oe active", 32'(sdo_oe), 1);
    frame_n = 1'b1; idle(HALF);
    sclk_pulse();
  endtask

  task automatic t_chain();
    logic [63:0] v;
    int bad;
    chain_en = 1'b1;
    v = {32'h0, 16'h1234, 16'hBEEF};
    run_frame(v, 32);
    check(pulses == 1 && cap == 16'hBEEF, "R5 last 16 kept", 32'(cap), 32'hBEEF);
    bad = 0;
    for (int k = 15; k < 32; k++) if (sdo_log[k] !== v[31-(k-15)]) bad++;
    check(bad == 0, "R6 sdo delay", 32'(bad), 0);
    sclk_pulse();
    run_frame(64'h5A, 8);
    check(pulses == 0 && word == 16'hBEEF, "R5 short chained", 32'(word), 32'hBEEF);
    sclk_pulse();
  endtask

  task automatic t_rearm();
    chain_en = 1'b1;
    run_frame(64'h4444, 16);
    check(cap == 16'h4444, "R7 armed commit", 32'(cap), 32'h4444);
    run_frame(64'h5555, 16);
    check(pulses == 0 && word == 16'h4444, "R7 not rearmed", 32'(word), 32'h4444);
    sclk_pulse();
    run_frame(64'h6789, 16);
    check(pulses == 1 && cap == 16'h6789, "R7 rearmed", 32'(cap), 32'h6789);
    sclk_pulse();
    chain_en = 1'b0;
    run_frame(64'hC001, 16);
    run_frame(64'hD00D, 16);
    check(pulses == 1 && cap == 16'hD00D, "R7 b2b single", 32'(cap), 32'hD00D);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0; idle(2);
    check(word == 16'h0 && valid == 1'b0, "R8 reset clears", 32'(word), 0);
    rst_n = 1'b1; idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_exact();
    t_short();
    t_long();
    t_oe();
    t_chain();
    t_rearm();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule